// File: doc/BRIEF.md
# General-Purpose I/O Port with Read-Modify-Write Bit Operations

This block is an eight-pin bidirectional I/O port. It holds three views of the pins. A direction register makes each pin either an input or an output. An output latch holds the level each output pin drives. A port view returns the synchronized levels seen on the pads. Each pin drives an output value and an output-enable to an external tri-state pad, and it receives the pad level back.

Software reaches the port over a small request bus. The bus offers whole-byte writes, whole-byte reads, and single-bit set and clear operations. Each operation targets the port view, the latch view or the direction register. Every accepted request runs through four phases:

- capture
- source sample
- modify
- write-back with read result

A single-bit operation aimed at the port view uses the live pin levels as its source. It then writes all eight bits into the output latch. As a result, latch bits of input pins can change without any warning. The same operation aimed at the latch view uses the latch itself as its source and leaves the other bits alone. An open-drain line is emulated by keeping a latch bit at 0 and toggling only its direction bit.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset, every direction bit is 1 and every latch bit is 0. Therefore `pad_oe` is 8'h00 and `pad_out` is 8'h00.
- R2: `pad_oe[i]` is the inverse of direction bit i, where 0 means output. `pad_out` always presents the output latch.
- R3: Writing the direction register, by byte or by bit, never changes the output latch. A pin that turns back into an output drives its earlier latch level.
- R4: A byte read of the port view (`req_sel`=0) returns the synchronized pad levels and not the latch. No read changes the latch.
- R5: The latch changes only in the write-back phase of a byte write, set or clear aimed at the port view (`req_sel`=0) or the latch view (`req_sel`=1). The operation codes are 0 for a byte write, 1 for a byte read, 2 for a bit set and 3 for a bit clear.
- R6: A bit set or clear on the port view takes all eight synchronized pad levels and changes only bit `req_bit`. It writes the result into the latch, so an input pin whose latch is 0 and whose pad is high ends up with a latch of 1.
- R7: A bit set or clear on the latch view (`req_sel`=1) changes only bit `req_bit` of the latch. Every other latch bit keeps its value.
- R8: A bit set or clear on the direction register (`req_sel`=2) changes only the addressed direction bit. A byte read with `req_sel`=1 or 2 returns the latch or the direction register.
- R9: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low during the first three phases. A read result shows `rd_valid` in the fourth phase, four edges after acceptance. The pads pass through a two-flop synchronizer and are sampled at the end of the first phase, so a pad change one cycle before acceptance is not seen.
- R10: Holding a latch bit at 0 and toggling its direction bit drives the pin low when the direction bit is 0. It releases the pin (`pad_oe` low) when the direction bit is 1, and the latch stays 0.
- R11: Register select 3 is reserved. A write to it changes neither the latch nor the direction register, and a read of it returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can take a request this edge |
| req_op | input | 2 | 0 byte write, 1 byte read, 2 bit set, 3 bit clear |
| req_sel | input | 2 | 0 port view, 1 latch view, 2 direction, 3 reserved |
| req_bit | input | 3 | Bit index for set and clear |
| req_wdata | input | 8 | Byte write data |
| rd_valid | output | 1 | Read result valid (fourth phase) |
| rd_data | output | 8 | Read result |
| pad_in | input | 8 | Pad levels from the pins |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Drive enable per pad, 1 drives |

## Verification
The main pattern is a bit set on the port view with a latch of zero and high pads on input pins. Its result tells a true read-modify-write of the pad levels apart from a latch-only update, and the same set on the latch view checks the opposite outcome. Alternating byte patterns such as A5 and 3C on the pads and the latch show that a port read returns the pads and a latch read returns the latch. Direction writes made while a latch pattern is held show that the latch is never disturbed. A pad change placed one cycle before acceptance shows that the two-flop synchronizer sits in front of the first-phase sample.

// File: rtl/gpio_rmw_pkg.sv
// Package: shared encodings for the GPIO port.
// Assumes: the request bus uses 2-bit codes for operation and register select.
package gpio_rmw_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEL_PORT  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_RSVD  = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4
    } phase_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes: each pad bit is asynchronous to clk and is sampled independently of the others.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pad levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value on one stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_phase_seq.sv
// Module: four-phase sequencer and request capture.
// Assumes: one request at a time. A new request may be taken in the idle state or in the
// last phase, so operations can run back to back.
module gpio_phase_seq
    import gpio_rmw_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_sel,
    input  logic [IDXW-1:0]  req_bit,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             req_ready,
    output phase_e           phase,
    output op_e              op_q,
    output sel_e             sel_q,
    output logic [IDXW-1:0]  bit_q,
    output logic [WIDTH-1:0] wdata_q
);
    logic accept;

    assign req_ready = (phase == PH_IDLE) || (phase == PH_Q4);
    assign accept    = req_valid && req_ready;

    // Advance through the four phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (accept) begin
            phase <= PH_Q1;
        end else begin
            case (phase)
                PH_Q1:   phase <= PH_Q2;
                PH_Q2:   phase <= PH_Q3;
                PH_Q3:   phase <= PH_Q4;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Hold the accepted request for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            sel_q   <= SEL_RSVD;
            bit_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= op_e'(req_op);
            sel_q   <= sel_e'(req_sel);
            bit_q   <= req_bit;
            wdata_q <= req_wdata;
        end
    end

    AST_ACCEPT_STARTS_Q1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (phase == PH_Q1)) else $error("accept did not start phase 1"); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready) else $error("ready high in phase 1"); // R9
endmodule

// File: rtl/gpio_rmw_datapath.sv
// Module: sample, modify and write-back datapath holding the latch and direction registers.
// Assumes: the phase comes from gpio_phase_seq, and the pin input is already synchronized.
module gpio_rmw_datapath
    import gpio_rmw_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  op_e              op_q,
    input  sel_e             sel_q,
    input  logic [IDXW-1:0]  bit_q,
    input  logic [WIDTH-1:0] wdata_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] smp_q;
    logic [WIDTH-1:0] mod_q;
    logic [WIDTH-1:0] bit_mask;
    logic             wr_phase;
    logic             targets_latch;

    assign bit_mask      = WIDTH'(1) << bit_q;
    assign wr_phase      = (phase == PH_Q3) && (op_q != OP_READ);
    assign targets_latch = (sel_q == SEL_PORT) || (sel_q == SEL_LATCH);

    // First phase: sample the source (pads for the port view, latch for the latch view).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else if (phase == PH_Q1) begin
            case (sel_q)
                SEL_PORT:  smp_q <= pins_sync;
                SEL_LATCH: smp_q <= lat_q;
                SEL_DIR:   smp_q <= dir_q;
                default:   smp_q <= '0;
            endcase
        end
    end

    // Second phase: form the value to write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (phase == PH_Q2) begin
            case (op_q)
                OP_WRITE: mod_q <= wdata_q;
                OP_SET:   mod_q <= smp_q | bit_mask;
                OP_CLEAR: mod_q <= smp_q & ~bit_mask;
                default:  mod_q <= smp_q;
            endcase
        end
    end

    // Third phase: write back into the latch (port or latch view).
    always_ff @(posedge clk) begin
        if (!rst_n)                         lat_q <= '0;
        else if (wr_phase && targets_latch) lat_q <= mod_q;
    end

    // Third phase: write back into the direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             dir_q <= '1;
        else if (wr_phase && sel_q == SEL_DIR)  dir_q <= mod_q;
    end

    // Present read results during the fourth phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (phase == PH_Q3) && (op_q == OP_READ);
            rd_data  <= ((phase == PH_Q3) && (op_q == OP_READ)) ? smp_q : '0;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '1 && lat_q == '0)) else $error("reset state wrong"); // R1
    AST_DIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q3 && sel_q == SEL_DIR) |=> $stable(lat_q)) else $error("dir write hit latch"); // R3
    AST_LATCH_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_q) |-> $past(phase == PH_Q3 && op_q != OP_READ
                                 && (sel_q == SEL_PORT || sel_q == SEL_LATCH)))
        else $error("latch changed outside write-back"); // R5
    AST_LATCH_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q3 && sel_q == SEL_LATCH && (op_q == OP_SET || op_q == OP_CLEAR))
        |=> ($countones(lat_q ^ $past(lat_q)) <= 1)) else $error("latch bit op touched >1 bit"); // R7
    AST_DIR_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q3 && sel_q == SEL_DIR && (op_q == OP_SET || op_q == OP_CLEAR))
        |=> ($countones(dir_q ^ $past(dir_q)) <= 1)) else $error("dir bit op touched >1 bit"); // R8
    AST_RSVD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q3 && sel_q == SEL_RSVD) |=> ($stable(lat_q) && $stable(dir_q)))
        else $error("reserved select had effect"); // R11
    AST_RD_IN_Q4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (phase == PH_Q4)) else $error("read result outside phase 4"); // R9
endmodule

// File: rtl/gpio_rmw_port.sv
// Module: top of the 8-pin GPIO port with read-modify-write bit operations.
// Assumes: an external tri-state pad per pin. pad_in is asynchronous. All requests use the
// valid/ready handshake and take four phases.
module gpio_rmw_port
    import gpio_rmw_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW       = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_sel,
    input  logic [IDXW-1:0]  req_bit,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    phase_e           phase;
    op_e              op_q;
    sel_e             sel_q;
    logic [IDXW-1:0]  bit_q;
    logic [WIDTH-1:0] wdata_q;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pins_sync)
    );

    gpio_phase_seq #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_bit(req_bit), .req_wdata(req_wdata),
        .req_ready(req_ready), .phase(phase), .op_q(op_q), .sel_q(sel_q),
        .bit_q(bit_q), .wdata_q(wdata_q)
    );

    gpio_rmw_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .op_q(op_q), .sel_q(sel_q),
        .bit_q(bit_q), .wdata_q(wdata_q), .pins_sync(pins_sync),
        .lat_q(lat_q), .dir_q(dir_q), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Pad drive: direction bit 0 enables the driver, and the latch gives the level.
    assign pad_out = lat_q;
    assign pad_oe  = ~dir_q;

    AST_PADOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_Q3) |=> $stable(pad_out)) else $error("pad_out moved outside write-back"); // R2
    AST_OE_HOLDS_ON_LATCH_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_Q3 && sel_q != SEL_DIR) |=> $stable(pad_oe)) else $error("oe moved"); // R10
endmodule

// File: tb/gpio_rmw_port_test.sv
// Bench: a driver task issues requests and pushes the expected read data into a queue, and a
// monitor pops the queue and compares when rd_valid shows.
module gpio_rmw_port_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPS = 2'd2, OPC = 2'd3;
    localparam logic [1:0] SP = 2'd0, SL = 2'd1, SD = 2'd2, SR = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = '0;
    logic [1:0] req_sel = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] req_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    gpio_rmw_port uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare every read result.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected read", rd_data, 8'hxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: issue one request, and return in its fourth phase.
    task automatic issue(logic [1:0] op, logic [1:0] sel, logic [2:0] b, logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel; req_bit = b; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(logic [1:0] sel, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(OPR, sel, 3'd0, 8'h00);
    endtask

    task automatic set_pads(logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", pad_oe, 8'h00);
        check("R1 out after reset", pad_out, 8'h00);
        rd(SD, 8'hFF, "R1 dir reset");
        rd(SL, 8'h00, "R1 latch reset");

        // Port read returns pads, not the latch.
        set_pads(8'hA5);
        rd(SP, 8'hA5, "R4 port read pads");
        rd(SL, 8'h00, "R4 read left latch");

        // Byte write through the port view updates the latch.
        issue(OPW, SP, 3'd0, 8'h3C);
        check("R5 byte write latch", pad_out, 8'h3C);
        check("R2 oe all inputs", pad_oe, 8'h00);
        issue(OPW, SD, 3'd0, 8'hF0);
        check("R2 oe follows dir", pad_oe, 8'h0F);
        check("R3 dir write keeps latch", pad_out, 8'h3C);
        rd(SL, 8'h3C, "R8 latch read");
        rd(SP, 8'hA5, "R4 port not latch");
        issue(OPW, SD, 3'd0, 8'h00);
        issue(OPW, SD, 3'd0, 8'hFF);
        check("R3 dir toggles keep latch", pad_out, 8'h3C);

        // Read-modify-write hazard on the port view.
        issue(OPW, SL, 3'd0, 8'h00);
        issue(OPW, SD, 3'd0, 8'hFE);
        set_pads(8'h82);
        issue(OPS, SP, 3'd0, 8'h00);
        check("R6 port bit set copies pads", pad_out, 8'h83);
        rd(SL, 8'h83, "R6 latch after port set");
        issue(OPW, SL, 3'd0, 8'hFF);
        set_pads(8'hF0);
        issue(OPC, SP, 3'd4, 8'h00);
        check("R6 port bit clear", pad_out, 8'hE0);

        // Latch-view bit ops keep the other bits.
        issue(OPW, SL, 3'd0, 8'h00);
        set_pads(8'hFF);
        issue(OPS, SL, 3'd5, 8'h00);
        check("R7 latch bit set", pad_out, 8'h20);
        issue(OPS, SL, 3'd0, 8'h00);
        issue(OPC, SL, 3'd5, 8'h00);
        check("R7 latch bit clear", pad_out, 8'h01);

        // Direction bit ops.
        issue(OPW, SD, 3'd0, 8'hFF);
        issue(OPC, SD, 3'd2, 8'h00);
        check("R8 dir bit clear", pad_oe, 8'h04);
        rd(SD, 8'hFB, "R8 dir read");
        issue(OPS, SD, 3'd2, 8'h00);
        check("R8 dir bit set", pad_oe, 8'h00);

        // Open-drain emulation on pin 3.
        issue(OPW, SL, 3'd0, 8'h00);
        issue(OPC, SD, 3'd3, 8'h00);
        check("R10 od drive low oe", pad_oe, 8'h08);
        check("R10 od drive low level", pad_out, 8'h00);
        issue(OPS, SD, 3'd3, 8'h00);
        check("R10 od release oe", pad_oe, 8'h00);
        check("R10 od latch stays 0", pad_out, 8'h00);

        // Reserved select.
        issue(OPW, SR, 3'd0, 8'h55);
        check("R11 reserved write latch", pad_out, 8'h00);
        check("R11 reserved write dir", pad_oe, 8'h00);
        rd(SR, 8'h00, "R11 reserved read");

        // Timing: ready drops, result in the fourth phase.
        begin
            int n;
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            exp_q.push_back(8'h00); tag_q.push_back("R9 timed read");
            req_valid = 1'b1; req_op = OPR; req_sel = SL;
            @(negedge clk);
            req_valid = 1'b0;
            check("R9 ready low in phase 1", {7'd0, req_ready}, 8'h00);
            n = 1;
            while (!rd_valid && n < 8) begin
                @(negedge clk);
                n++;
            end
            check("R9 rd_valid cycle", 8'(n), 8'd4);
        end

        // Synchronizer: a pad change one cycle before acceptance is not seen.
        set_pads(8'h11);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pad_in = 8'h66;
        exp_q.push_back(8'h11); tag_q.push_back("R9 sync hides late change");
        req_valid = 1'b1; req_op = OPR; req_sel = SP;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rd(SP, 8'h66, "R9 sync later sees change");

        repeat (4) @(negedge clk);
        check("R9 all reads returned", 8'(exp_q.size()), 8'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule